// File: doc/BRIEF.md
# Multi-Cycle Register-Machine Core with Matrix Offload

This block is a compact multi-cycle processor core. It fetches 32-bit instruction words one at a time, decodes them and executes them over a register file whose register count and width are parameters. The instruction set covers register and immediate arithmetic, bitwise logic, logical shifts, word and byte memory access, a conditional relative branch, a register-indirect jump, a halt, and two matrix commands. The matrix commands are not computed in the core. They are passed to an external matrix engine, and the core waits until that engine reports completion.

Each instruction word has four byte fields. Bits [31:24] hold the opcode. Bits [23:16] hold field F1, bits [15:8] hold field F2 and bits [7:0] hold field F3. A register operand uses the low log2(NREG) bits of its field. The core talks to three external agents. Instruction fetch and data access each use a valid/ready handshake. The core raises valid and holds the address and data steady until ready is seen in the same cycle. Back-pressure from either memory simply lengthens the current instruction, and a read returns its data in the cycle of acceptance. The matrix port is a plain request held high until a one-cycle done pulse. A free-running cycle counter and a halted flag show progress.

Opcodes: 00 halt, 01 move-immediate, 02 add-immediate, 03 add, 04 multiply, 05 or, 06 and, 07 xor, 08 shift-left, 09 shift-right, 0A not, 10 load-word, 11 store-word, 12 load-byte, 13 store-byte, 20 branch-if-nonzero, 21 jump-register, 30 matrix-multiply, 31 matrix-add.

Top module: `regcore_top`

## Requirements
- R1: While reset is low, imem_addr is 0, cycle_count is 0, halted is 0, and dmem_valid and mx_req are 0. After reset every register reads as zero.
- R2: Move-immediate (01) writes register F1 with the 16-bit value {F2,F3}, sign-extended to the data width.
- R3: The register operations (03 add, 04 multiply, 05 or, 06 and, 07 xor, 08 shift-left, 09 shift-right) write F1 with reg[F2] op reg[F3]. Add and multiply keep the low data-width bits. Shifts are logical and use only the low log2(DW) bits of reg[F3].
- R4: Not (0A) writes F1 with ~reg[F2]. Add-immediate (02) writes F1 with reg[F2] plus F3, where F3 is sign-extended.
- R5: Word load (10) and word store (11) use the byte address reg[F2] + sign-extended F3, with dmem_byte low. A store writes reg[F1]. A load writes the returned word to F1. The bench memory places bytes little-endian.
- R6: Byte load (12) writes F1 with dmem_rdata[7:0], zero-extended. Byte store (13) raises dmem_byte, and only the lowest byte of reg[F1] is written; neighbouring bytes keep their contents.
- R7: Once dmem_valid rises, it stays high with dmem_addr, dmem_wdata, dmem_we and dmem_byte unchanged until dmem_ready. Results do not depend on ready delays.
- R8: Branch (20) sets the PC to PC + sign-extended F3 when reg[F1] is nonzero, and to PC + 1 otherwise.
- R9: Jump (21) sets the PC to the low PC-width bits of reg[F1].
- R10: Matrix multiply (30, mx_op 0) and matrix add (31, mx_op 1) raise mx_req with the identifiers F1, F2 and F3 on mx_id_a, mx_id_b and mx_id_c. These stay unchanged until mx_done, and the core does not advance until then.
- R11: Halt (00) raises halted. From then on imem_addr stays on the halt instruction's address, cycle_count is frozen, and no port requests anything.
- R12: cycle_count increases by one on every clock from reset release until the clock that enters halt, inclusive. With zero-wait agents, an ALU, branch, jump or halt instruction takes 2 cycles, a memory instruction takes 3, and a matrix instruction takes 2 plus the cycles spent waiting for done.
- R13: imem_valid is high only while fetching. Fetch holds imem_addr until imem_ready. At most one of imem_valid, dmem_valid and mx_req is high at a time.
- R14: Any opcode not listed above behaves as a no-op that advances the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | PCW | Instruction word address (current PC) |
| imem_valid | output | 1 | Fetch request |
| imem_ready | input | 1 | Fetch accepted; imem_rdata valid this cycle |
| imem_rdata | input | 32 | Instruction word |
| dmem_valid | output | 1 | Data access request |
| dmem_ready | input | 1 | Data access accepted |
| dmem_we | output | 1 | 1 = write, 0 = read |
| dmem_byte | output | 1 | 1 = single byte, 0 = full word |
| dmem_addr | output | DW | Byte address |
| dmem_wdata | output | DW | Store data (source register) |
| dmem_rdata | input | DW | Load data, valid with dmem_ready |
| mx_req | output | 1 | Matrix command pending |
| mx_op | output | 1 | 0 = multiply, 1 = add |
| mx_id_a | output | 8 | First matrix identifier |
| mx_id_b | output | 8 | Second matrix identifier |
| mx_id_c | output | 8 | Third matrix identifier |
| mx_done | input | 1 | One-cycle completion pulse |
| halted | output | 1 | Core has executed halt |
| cycle_count | output | CW | Executed cycle count |

## Verification
The in-RTL assertions check the protocol-level behaviour on every cycle:
- data and matrix requests hold steady until they are accepted,
- fetch waits on imem_ready with a stable address,
- only one port requests at a time,
- the counter steps by exactly one while running,
- halt freezes the PC and the counter and silences all ports.

Only the bench scenarios can show that each opcode produces the right value. The same goes for base-plus-offset addressing, zero extension, lane isolation on byte stores, and the targets of taken and not-taken branches and jumps. The bench scenarios also confirm the exact cycle totals, and that running with stalled memories gives the same results as running without stalls.

// File: rtl/regcore_pkg.sv
package regcore_pkg;

  localparam logic [7:0] OP_HALT = 8'h00;
  localparam logic [7:0] OP_MOVI = 8'h01;
  localparam logic [7:0] OP_ADDI = 8'h02;
  localparam logic [7:0] OP_ADD  = 8'h03;
  localparam logic [7:0] OP_MUL  = 8'h04;
  localparam logic [7:0] OP_OR   = 8'h05;
  localparam logic [7:0] OP_AND  = 8'h06;
  localparam logic [7:0] OP_XOR  = 8'h07;
  localparam logic [7:0] OP_SHL  = 8'h08;
  localparam logic [7:0] OP_SHR  = 8'h09;
  localparam logic [7:0] OP_NOT  = 8'h0A;
  localparam logic [7:0] OP_LDW  = 8'h10;
  localparam logic [7:0] OP_STW  = 8'h11;
  localparam logic [7:0] OP_LDB  = 8'h12;
  localparam logic [7:0] OP_STB  = 8'h13;
  localparam logic [7:0] OP_BNZ  = 8'h20;
  localparam logic [7:0] OP_JR   = 8'h21;
  localparam logic [7:0] OP_MMUL = 8'h30;
  localparam logic [7:0] OP_MADD = 8'h31;

  typedef enum logic [2:0] {
    K_NOP, K_ALU, K_LOAD, K_STORE, K_BRANCH, K_JUMP, K_MATRIX, K_HALT
  } kind_e;

  typedef enum logic [3:0] {
    A_ADD, A_MUL, A_OR, A_AND, A_XOR, A_SHL, A_SHR, A_NOT, A_PASSB
  } aluop_e;

  typedef enum logic [1:0] {
    B_REG, B_IMM8, B_IMM16
  } bsel_e;

  typedef struct packed {
    kind_e  kind;
    aluop_e alu;
    bsel_e  bsel;
    logic   byte_sz;
    logic   mx_add;
  } dec_t;

  typedef enum logic [2:0] {
    S_FETCH, S_EXEC, S_MEM, S_MX, S_HALT
  } state_e;

endpackage

// File: rtl/regcore_decode.sv
module regcore_decode
  import regcore_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec.kind    = K_NOP;
    dec.alu     = A_ADD;
    dec.bsel    = B_REG;
    dec.byte_sz = 1'b0;
    dec.mx_add  = 1'b0;
    case (opcode)
      OP_HALT: dec.kind = K_HALT;
      OP_MOVI: begin dec.kind = K_ALU; dec.alu = A_PASSB; dec.bsel = B_IMM16; end
      OP_ADDI: begin dec.kind = K_ALU; dec.alu = A_ADD;   dec.bsel = B_IMM8;  end
      OP_ADD:  begin dec.kind = K_ALU; dec.alu = A_ADD; end
      OP_MUL:  begin dec.kind = K_ALU; dec.alu = A_MUL; end
      OP_OR:   begin dec.kind = K_ALU; dec.alu = A_OR;  end
      OP_AND:  begin dec.kind = K_ALU; dec.alu = A_AND; end
      OP_XOR:  begin dec.kind = K_ALU; dec.alu = A_XOR; end
      OP_SHL:  begin dec.kind = K_ALU; dec.alu = A_SHL; end
      OP_SHR:  begin dec.kind = K_ALU; dec.alu = A_SHR; end
      OP_NOT:  begin dec.kind = K_ALU; dec.alu = A_NOT; end
      OP_LDW:  dec.kind = K_LOAD;
      OP_STW:  dec.kind = K_STORE;
      OP_LDB:  begin dec.kind = K_LOAD;  dec.byte_sz = 1'b1; end
      OP_STB:  begin dec.kind = K_STORE; dec.byte_sz = 1'b1; end
      OP_BNZ:  dec.kind = K_BRANCH;
      OP_JR:   dec.kind = K_JUMP;
      OP_MMUL: dec.kind = K_MATRIX;
      OP_MADD: begin dec.kind = K_MATRIX; dec.mx_add = 1'b1; end
      default: dec.kind = K_NOP;
    endcase
  end

endmodule

// File: rtl/regcore_regfile.sv
module regcore_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic [IDX_W-1:0] rc_idx,
  output logic [DW-1:0]    ra_val,
  output logic [DW-1:0]    rb_val,
  output logic [DW-1:0]    rc_val
);

  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (we && waddr == IDX_W'(i))
        regs[i] <= wdata;
    end
  end

  assign ra_val = regs[ra_idx];
  assign rb_val = regs[rb_idx];
  assign rc_val = regs[rc_idx];

endmodule

// File: rtl/regcore_alu.sv
module regcore_alu
  import regcore_pkg::*;
#(
  parameter int DW = 32,
  localparam int SHW = $clog2(DW)
) (
  input  aluop_e        op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  logic [SHW-1:0] sh;
  assign sh = b[SHW-1:0];

  always_comb begin
    case (op)
      A_ADD:   y = a + b;
      A_MUL:   y = a * b;
      A_OR:    y = a | b;
      A_AND:   y = a & b;
      A_XOR:   y = a ^ b;
      A_SHL:   y = a << sh;
      A_SHR:   y = a >> sh;
      A_NOT:   y = ~a;
      default: y = b;
    endcase
  end

endmodule

// File: rtl/regcore_top.sv
module regcore_top
  import regcore_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int PCW  = 16,
  parameter int CW   = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [PCW-1:0] imem_addr,
  output logic           imem_valid,
  input  logic           imem_ready,
  input  logic [31:0]    imem_rdata,
  output logic           dmem_valid,
  input  logic           dmem_ready,
  output logic           dmem_we,
  output logic           dmem_byte,
  output logic [DW-1:0]  dmem_addr,
  output logic [DW-1:0]  dmem_wdata,
  input  logic [DW-1:0]  dmem_rdata,
  output logic           mx_req,
  output logic           mx_op,
  output logic [7:0]     mx_id_a,
  output logic [7:0]     mx_id_b,
  output logic [7:0]     mx_id_c,
  input  logic           mx_done,
  output logic           halted,
  output logic [CW-1:0]  cycle_count
);

  state_e         state;
  logic [PCW-1:0] pc;
  logic [31:0]    ir;
  logic [CW-1:0]  cnt;
  dec_t           dec;

  logic [7:0] f1, f2, f3;
  assign f1 = ir[23:16];
  assign f2 = ir[15:8];
  assign f3 = ir[7:0];

  logic [DW-1:0] imm8, imm16;
  logic [PCW-1:0] br_off;
  assign imm8   = {{(DW-8){f3[7]}}, f3};
  assign imm16  = {{(DW-16){f2[7]}}, f2, f3};
  assign br_off = {{(PCW-8){f3[7]}}, f3};

  regcore_decode u_dec (
    .opcode (ir[31:24]),
    .dec    (dec)
  );

  logic             rf_we;
  logic [DW-1:0]    rf_wdata;
  logic [DW-1:0]    rf_a, rf_b, rf_c;
  logic [DW-1:0]    alu_b, alu_y;

  regcore_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .waddr  (f1[IDX_W-1:0]),
    .wdata  (rf_wdata),
    .ra_idx (f1[IDX_W-1:0]),
    .rb_idx (f2[IDX_W-1:0]),
    .rc_idx (f3[IDX_W-1:0]),
    .ra_val (rf_a),
    .rb_val (rf_b),
    .rc_val (rf_c)
  );

  always_comb begin
    case (dec.bsel)
      B_IMM8:  alu_b = imm8;
      B_IMM16: alu_b = imm16;
      default: alu_b = rf_c;
    endcase
  end

  regcore_alu #(.DW(DW)) u_alu (
    .op (dec.alu),
    .a  (rf_b),
    .b  (alu_b),
    .y  (alu_y)
  );

  // Register write: ALU result in EXEC, load data on an accepted read.
  logic load_done;
  assign load_done = (state == S_MEM) && dmem_ready && (dec.kind == K_LOAD);
  assign rf_we     = ((state == S_EXEC) && (dec.kind == K_ALU)) || load_done;
  assign rf_wdata  = load_done ? (dec.byte_sz ? {{(DW-8){1'b0}}, dmem_rdata[7:0]} : dmem_rdata)
                               : alu_y;

  // Main sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      case (state)
        S_FETCH: if (imem_ready) begin
          ir    <= imem_rdata;
          state <= S_EXEC;
        end
        S_EXEC: begin
          case (dec.kind)
            K_LOAD, K_STORE: state <= S_MEM;
            K_MATRIX:        state <= S_MX;
            K_HALT:          state <= S_HALT;
            K_BRANCH: begin
              pc    <= (rf_a != '0) ? pc + br_off : pc + PCW'(1);
              state <= S_FETCH;
            end
            K_JUMP: begin
              pc    <= rf_a[PCW-1:0];
              state <= S_FETCH;
            end
            default: begin
              pc    <= pc + PCW'(1);
              state <= S_FETCH;
            end
          endcase
        end
        S_MEM: if (dmem_ready) begin
          pc    <= pc + PCW'(1);
          state <= S_FETCH;
        end
        S_MX: if (mx_done) begin
          pc    <= pc + PCW'(1);
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  // Cycle counter: runs every clock until the core sits in halt.
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (state != S_HALT)
      cnt <= cnt + CW'(1);
  end

  assign imem_addr   = pc;
  assign imem_valid  = (state == S_FETCH);
  assign dmem_valid  = (state == S_MEM);
  assign dmem_we     = (dec.kind == K_STORE);
  assign dmem_byte   = dec.byte_sz;
  assign dmem_addr   = rf_b + imm8;
  assign dmem_wdata  = rf_a;
  assign mx_req      = (state == S_MX);
  assign mx_op       = dec.mx_add;
  assign mx_id_a     = f1;
  assign mx_id_b     = f2;
  assign mx_id_c     = f3;
  assign halted      = (state == S_HALT);
  assign cycle_count = cnt;

  // R7: a data request holds its contents until accepted
  a_r7_dmem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_valid && !dmem_ready |=> dmem_valid && $stable(dmem_addr) && $stable(dmem_wdata)
                                  && $stable(dmem_we) && $stable(dmem_byte));

  // R10: a matrix command holds until done
  a_r10_mx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mx_req && !mx_done |=> mx_req && $stable(mx_op) && $stable(mx_id_a)
                           && $stable(mx_id_b) && $stable(mx_id_c));

  // R11: halt freezes PC and counter
  a_r11_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(cycle_count) && $stable(imem_addr));

  // R11: halted core requests nothing
  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !imem_valid && !dmem_valid && !mx_req);

  // R12: counter advances by one per running clock
  a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> cycle_count == $past(cycle_count) + CW'(1));

  // R13: fetch waits for ready with a stable address
  a_r13_fetch_wait: assert property (@(posedge clk) disable iff (!rst_n)
    imem_valid && !imem_ready |=> imem_valid && $stable(imem_addr));

  // R13: one port at a time
  a_r13_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imem_valid, dmem_valid, mx_req}));

endmodule

// File: tb/tb_regcore_top.sv
module tb_regcore_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr;
  logic        imem_valid;
  logic        imem_ready = 1'b1;
  logic [31:0] imem_rdata;
  logic        dmem_valid;
  logic        dmem_ready = 1'b1;
  logic        dmem_we, dmem_byte;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        mx_req, mx_op;
  logic [7:0]  mx_id_a, mx_id_b, mx_id_c;
  logic        mx_done = 1'b0;
  logic        halted;
  logic [31:0] cycle_count;

  always #4 clk = ~clk;

  regcore_top dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_valid(imem_valid), .imem_ready(imem_ready), .imem_rdata(imem_rdata),
    .dmem_valid(dmem_valid), .dmem_ready(dmem_ready), .dmem_we(dmem_we), .dmem_byte(dmem_byte),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .mx_req(mx_req), .mx_op(mx_op), .mx_id_a(mx_id_a), .mx_id_b(mx_id_b), .mx_id_c(mx_id_c),
    .mx_done(mx_done), .halted(halted), .cycle_count(cycle_count)
  );

  // Models
  logic [31:0] imem [32];
  logic [7:0]  dmem [64];
  logic        stall = 1'b0;
  int          tick = 0;
  int          mxw = 0;
  int          mx_n = 0;
  logic [31:0] mx_log [4];
  int          n_chk = 0, n_fail = 0;

  assign imem_rdata = imem[imem_addr[4:0]];
  assign dmem_rdata = {dmem[dmem_addr[5:0] + 6'd3], dmem[dmem_addr[5:0] + 6'd2],
                       dmem[dmem_addr[5:0] + 6'd1], dmem[dmem_addr[5:0]]};

  always @(posedge clk) begin
    if (dmem_valid && dmem_ready && dmem_we) begin
      dmem[dmem_addr[5:0]] <= dmem_wdata[7:0];
      if (!dmem_byte) begin
        dmem[dmem_addr[5:0] + 6'd1] <= dmem_wdata[15:8];
        dmem[dmem_addr[5:0] + 6'd2] <= dmem_wdata[23:16];
        dmem[dmem_addr[5:0] + 6'd3] <= dmem_wdata[31:24];
      end
    end
    if (mx_req && mx_done && mx_n < 4) begin
      mx_log[mx_n] <= {7'd0, mx_op, mx_id_a, mx_id_b, mx_id_c};
      mx_n <= mx_n + 1;
    end
  end

  always @(negedge clk) begin
    tick <= tick + 1;
    dmem_ready <= stall ? (tick % 3 == 2) : 1'b1;
    imem_ready <= stall ? (tick % 2 == 1) : 1'b1;
    if (mx_req && !mx_done) begin
      if (mxw == 3) begin mx_done <= 1'b1; mxw <= 0; end
      else mxw <= mxw + 1;
    end else begin
      mx_done <= 1'b0;
      mxw <= 0;
    end
  end

  function automatic logic [31:0] ins(input logic [7:0] op, f1, f2, f3);
    return {op, f1, f2, f3};
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  function automatic logic [31:0] rdw(input int a);
    return {dmem[a+3], dmem[a+2], dmem[a+1], dmem[a]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) imem[i] = 32'h0;
    for (int i = 0; i < 64; i++) dmem[i] = pat(i);
  endtask

  task automatic run(input logic stl);
    int n;
    stall = stl;
    mx_n = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", 32'(imem_addr), 32'h0);
    chk("R1 count", cycle_count, 32'h0);
    chk("R1 flags", {29'd0, halted, dmem_valid, mx_req}, 32'h0);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) chk("watchdog halted", 32'h0, 32'h1);
  endtask

  localparam logic [71:0] VEC [13] = '{
    {8'h03, 16'h0005, 16'h0007, 32'h0000000C},
    {8'h03, 16'hFFFF, 16'h0001, 32'h00000000},
    {8'h04, 16'h0100, 16'h0300, 32'h00030000},
    {8'h04, 16'hFFFE, 16'h0003, 32'hFFFFFFFA},
    {8'h05, 16'h00F0, 16'h0F00, 32'h00000FF0},
    {8'h06, 16'hFFFF, 16'h1234, 32'h00001234},
    {8'h07, 16'h8000, 16'h00FF, 32'hFFFF80FF},
    {8'h08, 16'h0001, 16'h001F, 32'h80000000},
    {8'h08, 16'h0003, 16'h0024, 32'h00000030},
    {8'h09, 16'h8000, 16'h0004, 32'h0FFFF800},
    {8'h0A, 16'h00FF, 16'h0000, 32'hFFFFFF00},
    {8'h02, 16'h0010, 16'h00FE, 32'h0000000E},
    {8'h01, 16'h0000, 16'h8001, 32'hFFFF8001}
  };

  initial begin : wd
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog global timeout actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    logic [15:0] p0;
    // Vector walk: R2, R3, R4, R12
    for (int v = 0; v < 13; v++) begin
      logic [7:0]  op;
      logic [15:0] a, b;
      logic [31:0] e;
      string tag;
      {op, a, b, e} = VEC[v];
      clear_prog();
      imem[0] = ins(8'h01, 8'd1, a[15:8], a[7:0]);
      imem[1] = ins(8'h01, 8'd2, b[15:8], b[7:0]);
      if (op == 8'h01)      imem[2] = ins(8'h01, 8'd3, b[15:8], b[7:0]);
      else if (op == 8'h02) imem[2] = ins(8'h02, 8'd3, 8'd1, b[7:0]);
      else                  imem[2] = ins(op, 8'd3, 8'd1, 8'd2);
      imem[3] = ins(8'h11, 8'd3, 8'd0, 8'd0);
      imem[4] = 32'h0;
      run(1'b0);
      tag = (op == 8'h01) ? "R2 movi" : (op == 8'h02 || op == 8'h0A) ? "R4 not/addi" : "R3 alu";
      chk(tag, rdw(0), e);
      chk("R12 alu program cycles", cycle_count, 32'd11);
    end

    // R11 freeze after halt
    c0 = cycle_count;
    p0 = imem_addr;
    repeat (6) @(negedge clk);
    chk("R11 count frozen", cycle_count, c0);
    chk("R11 pc frozen on halt", 32'(imem_addr), 32'(p0));
    chk("R11 pc value", 32'(p0), 32'd4);
    chk("R11 quiet", {29'd0, imem_valid, dmem_valid, mx_req}, 32'h0);

    // R5 / R6 / R7 / R13: memory program, no stall then stalled
    for (int s = 0; s < 2; s++) begin
      clear_prog();
      imem[0] = ins(8'h01, 8'd1, 8'h00, 8'd16);
      imem[1] = ins(8'h10, 8'd2, 8'd1, 8'd4);
      imem[2] = ins(8'h11, 8'd2, 8'd1, 8'hF8);
      imem[3] = ins(8'h12, 8'd3, 8'd1, 8'd3);
      imem[4] = ins(8'h11, 8'd3, 8'd0, 8'd32);
      imem[5] = ins(8'h01, 8'd6, 8'h7A, 8'hBC);
      imem[6] = ins(8'h13, 8'd6, 8'd0, 8'd40);
      imem[7] = 32'h0;
      run(s == 1);
      chk(s ? "R7 R5 word copy stalled" : "R5 word copy", rdw(8),
          {pat(23), pat(22), pat(21), pat(20)});
      chk(s ? "R7 R6 byte load stalled" : "R6 byte load zext", rdw(32), {24'd0, pat(19)});
      chk(s ? "R13 R6 byte store stalled" : "R6 byte store", rdw(40),
          {pat(43), pat(42), pat(41), 8'hBC});
      if (s == 0) chk("R12 memory program cycles", cycle_count, 32'd21);
    end
    stall = 1'b0;

    // R8 branch
    clear_prog();
    imem[0] = ins(8'h01, 8'd1, 8'h00, 8'd5);
    imem[1] = ins(8'h01, 8'd2, 8'h00, 8'd0);
    imem[2] = ins(8'h02, 8'd2, 8'd2, 8'd3);
    imem[3] = ins(8'h02, 8'd1, 8'd1, 8'hFF);
    imem[4] = ins(8'h20, 8'd1, 8'd0, 8'hFE);
    imem[5] = ins(8'h11, 8'd2, 8'd0, 8'd0);
    imem[6] = ins(8'h20, 8'd0, 8'd0, 8'd5);
    imem[7] = ins(8'h11, 8'd1, 8'd0, 8'd4);
    imem[8] = 32'h0;
    run(1'b0);
    chk("R8 taken loop", rdw(0), 32'd15);
    chk("R8 not taken", rdw(4), 32'd0);
    chk("R8 halt pc", 32'(imem_addr), 32'd8);

    // R9 jump
    clear_prog();
    imem[0] = ins(8'h01, 8'd5, 8'h00, 8'd7);
    imem[1] = ins(8'h01, 8'd4, 8'h00, 8'd5);
    imem[2] = ins(8'h21, 8'd4, 8'd0, 8'd0);
    imem[3] = ins(8'h01, 8'd5, 8'h00, 8'd99);
    imem[4] = 32'h0;
    imem[5] = ins(8'h11, 8'd5, 8'd0, 8'd8);
    imem[6] = 32'h0;
    run(1'b0);
    chk("R9 jump skips", rdw(8), 32'd7);
    chk("R9 halt pc", 32'(imem_addr), 32'd6);

    // R14 unknown opcode, R1 registers cleared
    clear_prog();
    imem[0] = ins(8'h01, 8'd1, 8'h00, 8'd3);
    imem[1] = ins(8'hEE, 8'd1, 8'd1, 8'd1);
    imem[2] = ins(8'h11, 8'd1, 8'd0, 8'd0);
    imem[3] = ins(8'h11, 8'd9, 8'd0, 8'd12);
    imem[4] = 32'h0;
    run(1'b0);
    chk("R14 nop keeps reg", rdw(0), 32'd3);
    chk("R14 halt pc", 32'(imem_addr), 32'd4);
    chk("R1 reg zero after reset", rdw(12), 32'd0);

    // R10 matrix offload
    clear_prog();
    imem[0] = ins(8'h30, 8'd1, 8'd2, 8'd3);
    imem[1] = ins(8'h31, 8'd4, 8'd5, 8'd6);
    imem[2] = 32'h0;
    run(1'b0);
    @(negedge clk);
    chk("R10 command count", 32'(mx_n), 32'd2);
    chk("R10 multiply ids", mx_log[0], 32'h00010203);
    chk("R10 add ids", mx_log[1], 32'h01040506);
    chk("R10 R12 matrix cycles", cycle_count, 32'd14);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule